// File: doc/BRIEF.md
# Divider Configuration Loader with Diagnostic Select

This block holds the settings of a clock synthesizer's dividers: a 9-bit feedback divide value, two 3-bit output divide values (channel A and channel B) and a 2-bit diagnostic select. The settings reach the holding registers by one of two paths. The first is a set of parallel pins, used at power-up. The second is a three-wire serial port made of a serial clock, a data line and a load strobe, used later to retune the dividers. The holding registers drive the counter configuration outputs without change.

All logic runs on one system clock. The serial clock, serial data, load strobe and parallel-load control are asynchronous inputs. Each passes through a synchronizer, and an edge detector follows it. A 4-to-1 multiplexer drives one diagnostic output. It selects a constant zero, the top bit of the shift register, the feedback counter output, or the synthesized clock. The diagnostic select can be written only from the serial port, and it is cleared whenever the parallel path is in control.

Top module: `cfg_loader`

## Requirements
- R1: On each detected rising edge of `serClk`, the 17-bit shift register moves one place toward its MSB and takes the synchronized `serData` into bit 0.
- R2: On a detected falling edge of `serLoad` while `parLoadN` is HIGH, the shift register is copied into the holding registers. Bits [16:15] go to `cfgT`, [14:12] to `cfgNb`, [11:9] to `cfgNa` and [8:0] to `cfgM`. The serial frame order is therefore T1, T0, NB2..NB0, NA2..NA0, M8..M0, with M0 sent last.
- R3: While `parLoadN` is LOW, `cfgM`, `cfgNa` and `cfgNb` follow `parM`, `parNa` and `parNb`.
- R4: While `parLoadN` is LOW, `cfgT` is held at 2'b00. No parallel pin reaches `cfgT`.
- R5: `testOut` is 0 when `cfgT`=00, the shift-register MSB when 01, `mCountIn` when 10 and `synthClkIn` when 11.
- R6: After `parLoadN` goes HIGH, the holding registers keep the last values taken from the pins. Later pin changes and serial shifting without a commit leave them unchanged.
- R7: A falling edge of `serLoad` while `parLoadN` is LOW has no effect. The parallel path keeps priority.
- R8: While `rstN` is LOW, every holding register and the shift register read zero, so `testOut` is 0.
- R9: A rising edge of `serLoad` commits nothing. Only the falling edge loads.
- R10: With `cfgT`=01, every further serial clock moves the next stored bit onto `testOut`, so the shifted stream can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial shift clock (asynchronous, sampled) |
| serData | input | 1 | Serial data line |
| serLoad | input | 1 | Serial commit strobe; its falling edge loads |
| parLoadN | input | 1 | LOW: holding registers track the parallel pins |
| parM | input | 9 | Parallel feedback divide value |
| parNa | input | 3 | Parallel channel A divide value |
| parNb | input | 3 | Parallel channel B divide value |
| mCountIn | input | 1 | Feedback counter output, for diagnosis |
| synthClkIn | input | 1 | Synthesized output clock, for diagnosis |
| cfgM | output | 9 | Feedback divide setting |
| cfgNa | output | 3 | Channel A divide setting |
| cfgNb | output | 3 | Channel B divide setting |
| cfgT | output | 2 | Diagnostic select setting |
| testOut | output | 1 | Diagnostic output |

## Verification
A corrupt shift register goes unseen until a commit. At the commit it shows up on all four configuration outputs a few system clocks after the strobe falls. With select 01 it shows up earlier, one serial clock after the bad bit reaches the MSB, because `testOut` streams out every stored bit. A fault in the priority or edge logic shows as a commit that should not happen: `cfgT` becomes non-zero while the parallel path is in control, or the values change on the wrong strobe edge. Either shows within the synchronizer latency.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
    logic track;
  } ldrStrobes_t;

  typedef enum logic [1:0] {
    SEL_ZERO  = 2'b00,
    SEL_SHIFT = 2'b01,
    SEL_MCNT  = 2'b10,
    SEL_SYNTH = 2'b11
  } testSel_t;

endpackage

// File: rtl/ldr_sync.sv
module ldr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar i = 1; i < STAGES; i++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= '0;
      else       stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLoad,
  input  logic        parLoadN,
  output ldrStrobes_t strobes
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] rawIn, syncIn;
  logic serClkS, serDataS, serLoadS, parLoadNS;
  logic serClkPrev, serLoadPrev;

  assign rawIn = {serClk, serData, serLoad, parLoadN};

  ldr_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  assign {serClkS, serDataS, serLoadS, parLoadNS} = syncIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkPrev  <= 1'b0;
      serLoadPrev <= 1'b0;
    end else begin
      serClkPrev  <= serClkS;
      serLoadPrev <= serLoadS;
    end
  end

  always_comb begin
    strobes.track    = !parLoadNS;
    strobes.shiftEn  = serClkS && !serClkPrev;
    strobes.shiftBit = serDataS;
    strobes.commit   = serLoadPrev && !serLoadS && parLoadNS;
  end

  AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> !strobes.shiftEn);  // R1
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !strobes.commit);  // R2
endmodule

// File: rtl/ldr_data.sv
module ldr_data
  import cfg_loader_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 3,
  parameter int T_W = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  ldrStrobes_t    strobes,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parNa,
  input  logic [N_W-1:0] parNb,
  input  logic           mCountIn,
  input  logic           synthClkIn,
  output logic [M_W-1:0] cfgM,
  output logic [N_W-1:0] cfgNa,
  output logic [N_W-1:0] cfgNb,
  output logic [T_W-1:0] cfgT,
  output logic           testOut
);
  localparam int FRAME_W = T_W + 2*N_W + M_W;
  localparam int NA_LO   = M_W;
  localparam int NB_LO   = M_W + N_W;
  localparam int T_LO    = M_W + 2*N_W;

  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], strobes.shiftBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgM  <= '0;
      cfgNa <= '0;
      cfgNb <= '0;
      cfgT  <= '0;
    end else if (strobes.track) begin
      cfgM  <= parM;
      cfgNa <= parNa;
      cfgNb <= parNb;
      cfgT  <= '0;
    end else if (strobes.commit) begin
      cfgM  <= shiftReg[M_W-1:0];
      cfgNa <= shiftReg[NA_LO +: N_W];
      cfgNb <= shiftReg[NB_LO +: N_W];
      cfgT  <= shiftReg[T_LO +: T_W];
    end
  end

  always_comb begin
    unique case (testSel_t'(cfgT[1:0]))
      SEL_ZERO:  testOut = 1'b0;
      SEL_SHIFT: testOut = shiftReg[FRAME_W-1];
      SEL_MCNT:  testOut = mCountIn;
      SEL_SYNTH: testOut = synthClkIn;
      default:   testOut = 1'b0;
    endcase
  end

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> shiftReg == {$past(shiftReg[FRAME_W-2:0]), $past(strobes.shiftBit)});  // R1
  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.track) |=> (cfgM == $past(shiftReg[M_W-1:0]) && cfgT == $past(shiftReg[T_LO +: T_W])));  // R2
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.track |=> (cfgM == $past(parM) && cfgNa == $past(parNa) && cfgNb == $past(parNb)));  // R3
  AST_T_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.track |=> cfgT == '0);  // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.track && !strobes.commit) |=> ($stable(cfgM) && $stable(cfgNa) && $stable(cfgNb) && $stable(cfgT)));  // R6
  always_comb begin
    if (rstN && cfgT == '0) AST_ZERO_SEL: assert (!testOut);  // R5
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 3,
  parameter int T_W         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serLoad,
  input  logic           parLoadN,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parNa,
  input  logic [N_W-1:0] parNb,
  input  logic           mCountIn,
  input  logic           synthClkIn,
  output logic [M_W-1:0] cfgM,
  output logic [N_W-1:0] cfgNa,
  output logic [N_W-1:0] cfgNb,
  output logic [T_W-1:0] cfgT,
  output logic           testOut
);
  ldrStrobes_t strobes;

  ldr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .serClk   (serClk),
    .serData  (serData),
    .serLoad  (serLoad),
    .parLoadN (parLoadN),
    .strobes  (strobes)
  );

  ldr_data #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .parM       (parM),
    .parNa      (parNa),
    .parNb      (parNb),
    .mCountIn   (mCountIn),
    .synthClkIn (synthClkIn),
    .cfgM       (cfgM),
    .cfgNa      (cfgNa),
    .cfgNb      (cfgNb),
    .cfgT       (cfgT),
    .testOut    (testOut)
  );
endmodule

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0, parLoadN = 1'b0;
  logic [8:0] parM = '0;
  logic [2:0] parNa = '0, parNb = '0;
  logic mCountIn = 1'b0, synthClkIn = 1'b0;
  logic [8:0] cfgM;
  logic [2:0] cfgNa, cfgNb;
  logic [1:0] cfgT;
  logic testOut;

  int checks = 0;
  int errors = 0;
  logic [16:0] shadow;

  always #10 clk = ~clk;

  cfg_loader uut (.*);

  function automatic logic [16:0] mkFrame(logic [1:0] t, logic [2:0] nb, logic [2:0] na, logic [8:0] m);
    return {t, nb, na, m};
  endfunction

  function automatic logic expTest(logic [1:0] t, logic msb, logic mc, logic sc);
    case (t)
      2'b00:   return 1'b0;
      2'b01:   return msb;
      2'b10:   return mc;
      default: return sc;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    serData = b;
    waitClk(4);
    serClk = 1'b1;
    waitClk(4);
    serClk = 1'b0;
    waitClk(4);
    shadow = {shadow[15:0], b};
  endtask

  task automatic sendFrame(logic [16:0] f);
    for (int i = 16; i >= 0; i--) sendBit(f[i]);
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    waitClk(6);
    serLoad = 1'b0;
    waitClk(6);
  endtask

  task automatic chkCfg(string req, logic [16:0] f);
    chk(req, {23'd0, cfgT, cfgNb, cfgNa, cfgM}, {15'd0, f});
  endtask

  initial begin
    logic [16:0] frm, held;
    void'($urandom(32'h5EED_2024));
    waitClk(3);
    chkCfg("R8", 17'd0);
    chk("R8", testOut, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < 6; i++) begin
      parM = 9'($urandom); parNa = 3'($urandom); parNb = 3'($urandom);
      waitClk(6);
      chkCfg("R3", {2'b00, parNb, parNa, parM});
      chk("R4", cfgT, 2'b00);
    end

    parM = 9'h1A5; parNa = 3'd6; parNb = 3'd1;
    waitClk(6);
    held = {2'b00, 3'd1, 3'd6, 9'h1A5};
    parLoadN = 1'b1;
    waitClk(6);
    parM = 9'h02F; parNa = 3'd3; parNb = 3'd7;
    waitClk(6);
    chkCfg("R6", held);
    sendFrame(mkFrame(2'b11, 3'd2, 3'd4, 9'h133));
    chkCfg("R6", held);

    for (int i = 0; i < 8; i++) begin
      frm = mkFrame(2'(i), 3'($urandom), 3'($urandom), 9'($urandom));
      sendFrame(frm);
      pulseLoad();
      chkCfg("R2", frm);
      mCountIn = 1'($urandom); synthClkIn = 1'($urandom);
      #1;
      chk("R5", testOut, expTest(frm[16:15], shadow[16], mCountIn, synthClkIn));
      mCountIn = ~mCountIn; synthClkIn = ~synthClkIn;
      #1;
      chk("R5", testOut, expTest(frm[16:15], shadow[16], mCountIn, synthClkIn));
    end

    held = {cfgT, cfgNb, cfgNa, cfgM};
    frm = mkFrame(2'b01, 3'd5, 3'd0, 9'h0F0);
    sendFrame(frm);
    serLoad = 1'b1;
    waitClk(8);
    chkCfg("R9", held);
    serLoad = 1'b0;
    waitClk(6);
    chkCfg("R9", frm);

    for (int i = 0; i < 17; i++) begin
      sendBit(1'($urandom));
      chk("R10", testOut, shadow[16]);
      chk("R10", cfgT, 2'b01);
    end

    parM = 9'h0C3; parNa = 3'd2; parNb = 3'd5;
    parLoadN = 1'b0;
    waitClk(6);
    chk("R4", cfgT, 2'b00);
    sendFrame(mkFrame(2'b11, 3'd7, 3'd7, 9'h1FF));
    pulseLoad();
    chkCfg("R7", {2'b00, 3'd5, 3'd2, 9'h0C3});
    chk("R7", testOut, 1'b0);

    rstN = 1'b0;
    waitClk(2);
    chkCfg("R8", 17'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule